// File: doc/BRIEF.md
# Descriptor-Chained XOR DMA Channel

This block is one channel of a memory-to-memory engine. It walks a chain of descriptors held in memory. Each descriptor names a destination buffer, a byte count and up to eight source buffers. For every 32-bit word of the buffer, the channel reads the same word from each enabled source, combines them with XOR and writes the result to the destination. When copy mode is selected, only source 0 is used and the channel moves data unchanged.

The channel is started by pointing `next_ptr` at the head of a chain and pulsing `start`. After each descriptor it writes the status word back with the ownership flag cleared, and then follows the next pointer. A next pointer of zero ends the chain. `cur_desc` always shows the descriptor being worked on, or the last one handled. A descriptor that the engine does not own, or one with an unusable byte count, stops the channel with an error event. All memory traffic uses one word-wide port that holds a request until it is acknowledged.

Top module: `xor_dma_chan`

## Requirements
- R1: After reset, `chan_state` is 0 (idle), `cur_desc` is 0, no event pulses and `mem_req` is low.
- R2: A `start` pulse while the channel is not busy (state 0 idle or 2 halted) loads `cur_desc` from `next_ptr`, and `chan_state` reads 1 (busy) in the next cycle. A `start` pulse while busy has no effect on `cur_desc`.
- R3: A descriptor is 13 words at consecutive word addresses from its base: +0 status (bit 31 = engine owns), +4 next pointer, +8 command (bit i enables source i for i in 0..7, bit 31 enables the end-of-descriptor event), +12 destination, +16 byte count, +20 onward the source addresses 0..7.
- R4: In XOR mode, destination word i equals the XOR of word i of every enabled source. With no source enabled, the result is zero. Exactly byte count / 4 words are written.
- R5: In copy mode (`copy_mode`=1), destination word i equals word i of source 0, and the other enable bits are ignored.
- R6: After the last data write of a descriptor, its status word is written back with bit 31 cleared and its other bits unchanged.
- R7: `eod_evt` pulses once after a descriptor's status write-back only if command bit 31 is set.
- R8: After a descriptor whose next pointer is nonzero, the channel processes the descriptor at that address. After one whose next pointer is zero, `eoc_evt` pulses and `chan_state` returns to 0.
- R9: A descriptor whose status bit 31 is clear causes `err_evt` and `chan_state`=2, with no data write and no write-back.
- R10: A byte count below 128, above `max_bytes`, or not a multiple of 4 causes `err_evt` and `chan_state`=2, with the destination left untouched. A count equal to `max_bytes` is accepted.
- R11: With `desc_swap`=1, descriptor words are byte-reversed both when read and when the status is written back. Buffer data is never swapped.
- R12: `cur_desc` holds the address of the descriptor in progress, and after the chain ends it holds the address of the final descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Activation pulse |
| next_ptr | input | AW | Address of the chain head |
| copy_mode | input | 1 | 1 = copy from source 0, 0 = XOR of enabled sources |
| desc_swap | input | 1 | Byte-reverse descriptor words |
| max_bytes | input | BCW | Largest accepted byte count |
| chan_state | output | 2 | 0 idle, 1 busy, 2 halted on error |
| cur_desc | output | AW | Current or last descriptor address |
| eod_evt | output | 1 | End-of-descriptor pulse |
| eoc_evt | output | 1 | End-of-chain pulse |
| err_evt | output | 1 | Error pulse |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | AW | Byte address, word aligned |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The assertions assume a memory that raises `mem_ack` only while a request is pending, gives one acknowledge per request, and presents read data in the same cycle as that acknowledge. The bench model follows these rules. It answers a pending request on the falling edge, with a one-cycle gap between answers, and never acknowledges while no request is pending. The assertions also assume that `next_ptr`, `copy_mode`, `desc_swap` and `max_bytes` stay fixed while a chain runs. The bench changes them only between runs, except for the deliberate `start` pulse sent during a busy chain.

// File: rtl/xor_dma_chan.sv
module xor_dma_chan #(
  parameter int AW        = 32,
  parameter int NSRC      = 8,
  parameter int BCW       = 24,
  parameter int MIN_BYTES = 128,
  parameter int OWN_BIT   = 31,
  parameter int EOD_BIT   = 31
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [AW-1:0]  next_ptr,
  input  logic           copy_mode,
  input  logic           desc_swap,
  input  logic [BCW-1:0] max_bytes,
  output logic [1:0]     chan_state,
  output logic [AW-1:0]  cur_desc,
  output logic           eod_evt,
  output logic           eoc_evt,
  output logic           err_evt,
  output logic           mem_req,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [31:0]    mem_wdata,
  input  logic           mem_ack,
  input  logic [31:0]    mem_rdata
);
  localparam int NDW    = 5 + NSRC;
  localparam int FW     = $clog2(NDW + 1);
  localparam int SW     = $clog2(NSRC);
  localparam int WW     = BCW - 2;
  localparam int OWN_SW = (3 - OWN_BIT / 8) * 8 + OWN_BIT % 8;
  localparam logic [1:0] ST_IDLE = 2'd0, ST_BUSY = 2'd1, ST_HALT = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_HALT, S_FETCH, S_CHECK, S_RD, S_WR, S_WB, S_NEXT} fsm_t;

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  fsm_t            st;
  logic [FW-1:0]   fidx;
  logic [SW:0]     sidx;
  logic [WW-1:0]   widx;
  logic [31:0]     acc, stat_q, cmd_q;
  logic [AW-1:0]   nxt_q, dst_q;
  logic [BCW-1:0]  bc_q;
  logic [AW-1:0]   src_q [NSRC];

  logic [31:0]     rd_word, wb_raw;
  logic [NSRC-1:0] src_en;
  logic [FW-1:0]   fsrc;
  logic            src_done, cur_en, bc_bad, last_word, last_fetch;

  assign rd_word    = desc_swap ? bswap(mem_rdata) : mem_rdata;
  assign wb_raw     = stat_q & ~(32'd1 << OWN_BIT);
  assign src_en     = copy_mode ? NSRC'(1) : cmd_q[NSRC-1:0];
  assign src_done   = sidx == (SW+1)'(NSRC);
  assign cur_en     = !src_done && src_en[sidx[SW-1:0]];
  assign bc_bad     = (bc_q < BCW'(MIN_BYTES)) || (bc_q > max_bytes) || (bc_q[1:0] != 2'b00);
  assign last_word  = widx == (bc_q[BCW-1:2] - WW'(1));
  assign last_fetch = fidx == FW'(NDW - 1);
  assign fsrc       = fidx - FW'(5);

  assign chan_state = (st == S_IDLE) ? ST_IDLE : (st == S_HALT) ? ST_HALT : ST_BUSY;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st)
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cur_desc + AW'({fidx, 2'b00});
      end
      S_RD: begin
        mem_req  = cur_en;
        mem_addr = src_q[sidx[SW-1:0]] + AW'({widx, 2'b00});
      end
      S_WR: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = dst_q + AW'({widx, 2'b00});
        mem_wdata = acc;
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_desc;
        mem_wdata = desc_swap ? bswap(wb_raw) : wb_raw;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    eod_evt <= 1'b0;
    eoc_evt <= 1'b0;
    err_evt <= 1'b0;
    if (!rst_n) begin
      st       <= S_IDLE;
      cur_desc <= '0;
      fidx     <= '0;
      sidx     <= '0;
      widx     <= '0;
      acc      <= '0;
      stat_q   <= '0;
      cmd_q    <= '0;
      nxt_q    <= '0;
      dst_q    <= '0;
      bc_q     <= '0;
      for (int k = 0; k < NSRC; k++) src_q[k] <= '0;
    end else begin
      case (st)
        S_IDLE, S_HALT: if (start) begin
          cur_desc <= next_ptr;
          fidx     <= '0;
          st       <= S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          case (fidx)
            FW'(0): stat_q <= rd_word;
            FW'(1): nxt_q  <= AW'(rd_word);
            FW'(2): cmd_q  <= rd_word;
            FW'(3): dst_q  <= AW'(rd_word);
            FW'(4): bc_q   <= rd_word[BCW-1:0];
            default: src_q[fsrc[SW-1:0]] <= AW'(rd_word);
          endcase
          fidx <= fidx + FW'(1);
          if (last_fetch) st <= S_CHECK;
        end
        S_CHECK: begin
          if (!stat_q[OWN_BIT] || bc_bad) begin
            err_evt <= 1'b1;
            st      <= S_HALT;
          end else begin
            widx <= '0;
            sidx <= '0;
            acc  <= '0;
            st   <= S_RD;
          end
        end
        S_RD: begin
          if (src_done) st <= S_WR;
          else if (!cur_en) sidx <= sidx + 1'b1;
          else if (mem_ack) begin
            acc  <= acc ^ mem_rdata;
            sidx <= sidx + 1'b1;
          end
        end
        S_WR: if (mem_ack) begin
          if (last_word) st <= S_WB;
          else begin
            widx <= widx + WW'(1);
            sidx <= '0;
            acc  <= '0;
            st   <= S_RD;
          end
        end
        S_WB: if (mem_ack) begin
          eod_evt <= cmd_q[EOD_BIT];
          st      <= S_NEXT;
        end
        S_NEXT: begin
          if (nxt_q == '0) begin
            eoc_evt <= 1'b1;
            st      <= S_IDLE;
          end else begin
            cur_desc <= nxt_q;
            fidx     <= '0;
            st       <= S_FETCH;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_state != ST_BUSY) |-> !mem_req);

  p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && chan_state != ST_BUSY) |=> (cur_desc == $past(next_ptr) && chan_state == ST_BUSY));

  p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && chan_state == ST_BUSY && st != S_NEXT) |=> $stable(cur_desc));

  p_wb_owner_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && st == S_WB) |-> (desc_swap ? !mem_wdata[OWN_SW] : !mem_wdata[OWN_BIT]));

  p_eod_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eod_evt |-> $past(mem_we && mem_ack));

  p_evt_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({eoc_evt, err_evt}) && !(eod_evt && err_evt));

  p_end_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_evt |-> chan_state == ST_IDLE);

  p_err_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_evt |-> chan_state == ST_HALT);
endmodule

// File: tb/xor_dma_chan_bench.sv
`timescale 1ns/1ps
module xor_dma_chan_bench;
  localparam logic [31:0] SRC0 = 32'h400, DST = 32'h1800, DSTB = 32'h1900;
  localparam logic [31:0] DA = 32'h100, DB = 32'h140;
  // {5'd0, byte count[26:16], 5'd0, eod[10], swap[9], copy[8], mask[7:0]}
  localparam logic [31:0] VEC [0:5] = '{
    {5'd0, 11'd128, 5'd0, 1'b1, 1'b0, 1'b0, 8'h0F},
    {5'd0, 11'd256, 5'd0, 1'b1, 1'b0, 1'b0, 8'hFF},
    {5'd0, 11'd128, 5'd0, 1'b0, 1'b0, 1'b1, 8'h01},
    {5'd0, 11'd132, 5'd0, 1'b1, 1'b0, 1'b1, 8'h0A},
    {5'd0, 11'd128, 5'd0, 1'b1, 1'b0, 1'b0, 8'h00},
    {5'd0, 11'd160, 5'd0, 1'b1, 1'b1, 1'b0, 8'h05}
  };

  logic clk = 0, rst_n = 0, start = 0, copy_mode = 0, desc_swap = 0;
  logic [31:0] next_ptr = 0;
  logic [23:0] max_bytes = 24'd256;
  logic [1:0] chan_state;
  logic [31:0] cur_desc, mem_addr, mem_wdata, mem_rdata;
  logic eod_evt, eoc_evt, err_evt, mem_req, mem_we, mem_ack;
  logic put_en = 0;
  logic [31:0] put_addr = 0, put_data = 0;
  logic [31:0] mem [0:2047];
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  xor_dma_chan u_xor_dma_chan (
    .clk(clk), .rst_n(rst_n), .start(start), .next_ptr(next_ptr),
    .copy_mode(copy_mode), .desc_swap(desc_swap), .max_bytes(max_bytes),
    .chan_state(chan_state), .cur_desc(cur_desc), .eod_evt(eod_evt),
    .eoc_evt(eoc_evt), .err_evt(err_evt), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  always @(negedge clk) begin
    if (put_en) mem[put_addr[12:2]] <= put_data;
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[12:2]];
      if (mem_we) mem[mem_addr[12:2]] <= mem_wdata;
    end else mem_ack <= 1'b0;
  end

  function automatic logic [31:0] bsw(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [31:0] pat(input int s, input int i);
    return {8'(s + 1), 8'(i), 8'hA5 ^ 8'(s), 8'(i) ^ 8'h3C};
  endfunction

  function automatic logic [31:0] exp_word(input logic [7:0] mask, input logic cp, input int i);
    logic [31:0] e = 0;
    for (int s = 0; s < 8; s++)
      if (cp ? (s == 0) : mask[s]) e = e ^ pat(s, i);
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] d);
    @(posedge clk);
    put_en = 1; put_addr = a; put_data = d;
  endtask

  task automatic put_end();
    @(posedge clk);
    put_en = 0;
  endtask

  task automatic put_desc(input logic [31:0] base, input logic [31:0] stat, input logic [31:0] nxt,
                          input logic [31:0] cmd, input logic [31:0] dst, input logic [31:0] bc, input logic swp);
    put(base,      swp ? bsw(stat) : stat);
    put(base + 4,  swp ? bsw(nxt)  : nxt);
    put(base + 8,  swp ? bsw(cmd)  : cmd);
    put(base + 12, swp ? bsw(dst)  : dst);
    put(base + 16, swp ? bsw(bc)   : bc);
    for (int s = 0; s < 8; s++) begin
      logic [31:0] a = SRC0 + 32'(s) * 32'h200;
      put(base + 20 + 32'(4 * s), swp ? bsw(a) : a);
    end
  endtask

  task automatic kick(input logic [31:0] ptr);
    @(negedge clk);
    next_ptr = ptr; start = 1;
    @(negedge clk);
    start = 0;
  endtask

  task automatic wait_done(output int eods, output int eocs, output int errs);
    eods = 0; eocs = 0; errs = 0;
    for (int c = 0; c < 20000; c++) begin
      if (eod_evt) eods++;
      if (eoc_evt) eocs++;
      if (err_evt) errs++;
      if (eoc_evt || err_evt) break;
      @(negedge clk);
    end
  endtask

  task automatic data_check(input logic [31:0] dst, input int nw, input logic [7:0] mask,
                            input logic cp, input string tag);
    logic [31:0] act = 0, exp = 0;
    bit ok = 1;
    for (int i = 0; i <= nw; i++) begin
      logic [31:0] e = (i < nw) ? exp_word(mask, cp, i) : 32'h0;
      if (ok && mem[(dst >> 2) + 32'(i)] !== e) begin
        ok = 0; act = mem[(dst >> 2) + 32'(i)]; exp = e;
      end
    end
    check(ok, tag, act, exp);
  endtask

  task automatic err_case(input logic [31:0] stat, input logic [31:0] bc, input string tag);
    int eods, eocs, errs;
    put(DST, 32'hDEADBEEF);
    put_desc(DA, stat, 0, 32'h8000_0001, DST, bc, 1'b0);
    put_end();
    kick(DA);
    wait_done(eods, eocs, errs);
    check(errs == 1 && eocs == 0 && chan_state == 2'd2, tag, {30'(errs), chan_state}, 32'h6);
    check(mem[DST >> 2] == 32'hDEADBEEF && mem[DA >> 2] == stat, tag, mem[DST >> 2], 32'hDEADBEEF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual running expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int eods, eocs, errs;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(chan_state == 0 && cur_desc == 0 && !mem_req && !eod_evt && !eoc_evt && !err_evt,
          "R1 reset", {cur_desc[29:0], chan_state}, 32'h0);

    for (int s = 0; s < 8; s++)
      for (int i = 0; i < 64; i++) put(SRC0 + 32'(s) * 32'h200 + 32'(4 * i), pat(s, i));
    put_end();

    // R3 layout is used by every vector below
    for (int v = 0; v < 6; v++) begin
      logic [31:0] e = VEC[v];
      logic [7:0] mask = e[7:0];
      logic cp = e[8], swp = e[9], eod = e[10];
      logic [31:0] bc = {21'd0, e[26:16]};
      string tag = cp ? "R5 copy" : (swp ? "R11 swap" : "R4 xor");
      copy_mode = cp; desc_swap = swp;
      for (int i = 0; i < 65; i++) put(DST + 32'(4 * i), 32'h0);
      put_desc(DA, 32'h8000_00C3, 0, {eod, 23'd0, mask}, DST, bc, swp);
      put_end();
      kick(DA);
      wait_done(eods, eocs, errs);
      data_check(DST, int'(bc >> 2), mask, cp, tag);
      check((swp ? bsw(mem[DA >> 2]) : mem[DA >> 2]) == 32'h0000_00C3, "R6 writeback",
            mem[DA >> 2], 32'h0000_00C3);
      check(eods == int'(eod), "R7 eod", 32'(eods), 32'(eod));
      check(eocs == 1 && errs == 0 && chan_state == 0 && cur_desc == DA, "R8/R12 end",
            cur_desc, DA);
    end

    copy_mode = 0; desc_swap = 0;
    for (int i = 0; i < 33; i++) begin
      put(DST + 32'(4 * i), 32'h0);
      put(DSTB + 32'(4 * i), 32'h0);
    end
    put_desc(DA, 32'h8000_0011, DB, 32'h8000_0003, DST, 128, 1'b0);
    put_desc(DB, 32'h8000_0022, 0, 32'h0000_0003, DSTB, 128, 1'b0);
    put_end();
    kick(DA);
    check(cur_desc == DA && chan_state == 2'd1, "R2 start", cur_desc, DA);
    repeat (3) @(negedge clk);
    next_ptr = 32'h300; start = 1;
    @(negedge clk);
    start = 0;
    check(cur_desc == DA, "R2 start while busy ignored", cur_desc, DA);
    check(cur_desc == DA, "R12 current descriptor", cur_desc, DA);
    wait_done(eods, eocs, errs);
    check(eods == 1, "R7 eod only where enabled", 32'(eods), 32'd1);
    check(eocs == 1 && chan_state == 0 && cur_desc == DB, "R8/R12 chain end", cur_desc, DB);
    check(mem[DA >> 2] == 32'h11 && mem[DB >> 2] == 32'h22, "R6 chain writeback",
          mem[DB >> 2], 32'h22);
    data_check(DST, 32, 8'h03, 1'b0, "R4 chain first");
    data_check(DSTB, 32, 8'h03, 1'b0, "R8 chain second");

    err_case(32'h0000_00C3, 128, "R9 not owned");
    err_case(32'h8000_00C3, 124, "R10 short count");
    err_case(32'h8000_00C3, 260, "R10 over max");
    err_case(32'h8000_00C3, 130, "R10 unaligned count");

    for (int i = 0; i < 33; i++) put(DST + 32'(4 * i), 32'h0);
    put_desc(DA, 32'h8000_0000, 0, 32'h0000_0001, DST, 128, 1'b0);
    put_end();
    kick(DA);
    wait_done(eods, eocs, errs);
    check(eocs == 1 && chan_state == 0, "R2 restart after halt", {30'd0, chan_state}, 32'h0);
    data_check(DST, 32, 8'h01, 1'b0, "R4 restart data");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule